// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by counting down from a programmed timeout value. A fixed prescaler divides the clock, and each prescaler tick lowers the count by one. Software restarts the count with a two-write feed sequence. If the count runs out, the block signals a fault. A fault also occurs when a feed arrives too early, meaning the count is still above a programmable window value, and when the feed sequence is malformed. Depending on the mode, a fault produces either a one-cycle reset request to the chip reset generator or a level interrupt. A separate warning interrupt rises when the count reaches a programmable value.

Software controls the block through a simple write port, made of a strobe, a 3-bit address and write data. Every write is accepted in the cycle it is presented, so the port has no back-pressure. Software cannot clear the enable. Only a fault or a hardware reset clears it. The reset-mode bit can only be set. A sticky flag records that the watchdog requested a reset. All status appears on plain output pins and is cleared through a flag-clear register.

Register addresses are: 0 mode, 1 timeout, 2 window, 3 warning level, 4 feed, 5 flag clear.

Top module: `wdt_window`

## Requirements
- R1: After reset the following hold: the outputs `enabled_o`, `reset_req_o`, `irq_o`, `warn_o` and `wd_flag_o` are low; the count and the timeout and window registers are all ones; the warning register is zero.
- R2: Writing the mode register with bit 0 set while the block is disabled enables the block and loads the count from the timeout register. The count then decreases by one every 4 clocks. The first decrease appears 4 cycles after the loading write.
- R3: When a prescaler tick finds the count at zero, a timeout fault occurs. It is visible 4*(timeout+1) cycles after the enabling write, and it clears the enable.
- R4: A valid feed is a feed-register write of 0xAA (low byte), followed by a feed-register write of 0x55 as the very next register write. It reloads the count from the timeout register and restarts the prescaler.
- R5: A 0x55 feed completion that arrives while the count is above the window register is an early fault. It takes effect at that write's clock edge and does not reload the count.
- R6: While an 0xAA is pending, any register write other than a feed of 0x55 is a sequence fault. A feed write of any value other than 0xAA when nothing is pending is also a sequence fault.
- R7: Writing 0 to mode bit 0 while the block is enabled has no effect. The enable clears only on a fault or on `rst_n`.
- R8: Mode bit 1 is set-only and selects reset mode. In reset mode a fault gives a one-cycle `reset_req_o` pulse and sets `wd_flag_o`. In interrupt mode a fault sets `irq_o` instead.
- R9: While the block is enabled, a count equal to the warning register raises `warn_o` one cycle later.
- R10: A flag-clear write clears `irq_o` when bit 0 is set, `warn_o` when bit 1 is set, and `wd_flag_o` when bit 2 is set.
- R11: While the block is disabled, feed writes cause no fault and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Register write data |
| enabled_o | output | 1 | Watchdog running |
| reset_req_o | output | 1 | One-cycle reset request on a fault in reset mode |
| irq_o | output | 1 | Fault interrupt flag (interrupt mode) |
| warn_o | output | 1 | Warning interrupt flag |
| wd_flag_o | output | 1 | Sticky record of a watchdog reset request |
| count_o | output | CNT_W | Current count |

## Verification
Every result follows from a write edge at a fixed distance. Sequence faults and early faults appear at the write's own edge. Loads appear at the same edge, and decrements every fourth edge after that. A timeout shows up 4*(timeout+1) edges after the enabling write, and a warning one edge after the count matches. The bench records the cycle number of the write that completes each stimulus. It then queues each expected event with its exact cycle and kind, and a monitor samples on falling edges and matches every observed reset pulse, interrupt rise or warning rise against that queue. Count values are checked just before and just after the fourth edge, so an off-by-one in the prescaler fails the check.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MODE    = 3'd0;
  localparam logic [ADDR_W-1:0] A_TIMEOUT = 3'd1;
  localparam logic [ADDR_W-1:0] A_WINDOW  = 3'd2;
  localparam logic [ADDR_W-1:0] A_WARN    = 3'd3;
  localparam logic [ADDR_W-1:0] A_FEED    = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAGCLR = 3'd5;
  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick_o = run_i && !clr_i && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  phase_q <= '0;
    else if (clr_i || !run_i)    phase_q <= '0;
    else if (phase_q == LAST)    phase_q <= '0;
    else                         phase_q <= phase_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R2
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;

  assign count_o  = count_q;
  assign expire_o = tick_i && !load_i && (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         count_q <= '1;
    else if (load_i)                    count_q <= load_val_i;
    else if (tick_i && count_q != '0)   count_q <= count_q - 1'b1;
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> count_q == $past(load_val_i)); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(count_q)); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && count_q != '0) |=> count_q == $past(count_q) - 1'b1); // R2
endmodule

// File: rtl/wdt_feed_check.sv
module wdt_feed_check
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_byte_i,
  output logic              feed_ok_o,
  output logic              seq_err_o
);
  logic armed_q, armed_d;
  logic feed_wr;

  assign feed_wr = wr_en_i && (wr_addr_i == A_FEED);

  always_comb begin
    feed_ok_o = 1'b0;
    seq_err_o = 1'b0;
    armed_d   = armed_q;
    if (!active_i) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      if (feed_wr && wr_byte_i == KEY_SECOND) feed_ok_o = 1'b1;
      else if (wr_en_i)                       seq_err_o = 1'b1;
      if (wr_en_i) armed_d = 1'b0;
    end else if (feed_wr) begin
      if (wr_byte_i == KEY_FIRST) armed_d   = 1'b1;
      else                        seq_err_o = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  AST_OK_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_ok_o || seq_err_o) |-> active_i); // R11
  AST_OK_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok_o |=> !armed_q); // R4
endmodule

// File: rtl/wdt_window.sv
module wdt_window
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int PRE_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              enabled_o,
  output logic              reset_req_o,
  output logic              irq_o,
  output logic              warn_o,
  output logic              wd_flag_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [CNT_W-1:0] timeout_q, window_q, warn_q;
  logic enable_q, rst_mode_q, irq_q, warn_q_f, wd_flag_q, rst_req_q;
  logic tick, expire, feed_ok, seq_err, early, load, fault, en_set;
  logic [CNT_W-1:0] count;

  function automatic logic hit(input logic [2:0] a);
    return wr_en && (wr_addr == a);
  endfunction

  assign en_set = hit(A_MODE) && wr_data[0] && !enable_q;
  assign early  = feed_ok && (count > window_q);
  assign load   = en_set || (feed_ok && !early);
  assign fault  = expire || early || seq_err;

  wdt_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(enable_q), .clr_i(load), .tick_o(tick));

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(timeout_q),
    .tick_i(tick), .count_o(count), .expire_o(expire));

  wdt_feed_check u_feed (
    .clk(clk), .rst_n(rst_n), .active_i(enable_q), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_byte_i(wr_data[7:0]),
    .feed_ok_o(feed_ok), .seq_err_o(seq_err));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeout_q <= '1;
      window_q  <= '1;
      warn_q    <= '0;
    end else begin
      if (hit(A_TIMEOUT)) timeout_q <= wr_data;
      if (hit(A_WINDOW))  window_q  <= wr_data;
      if (hit(A_WARN))    warn_q    <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q   <= 1'b0;
      rst_mode_q <= 1'b0;
      irq_q      <= 1'b0;
      warn_q_f   <= 1'b0;
      wd_flag_q  <= 1'b0;
      rst_req_q  <= 1'b0;
    end else begin
      if (fault)       enable_q <= 1'b0;
      else if (en_set) enable_q <= 1'b1;
      if (hit(A_MODE) && wr_data[1]) rst_mode_q <= 1'b1;
      rst_req_q <= fault && rst_mode_q;
      if (fault && !rst_mode_q)                 irq_q <= 1'b1;
      else if (hit(A_FLAGCLR) && wr_data[0])    irq_q <= 1'b0;
      if (enable_q && count == warn_q)          warn_q_f <= 1'b1;
      else if (hit(A_FLAGCLR) && wr_data[1])    warn_q_f <= 1'b0;
      if (fault && rst_mode_q)                  wd_flag_q <= 1'b1;
      else if (hit(A_FLAGCLR) && wr_data[2])    wd_flag_q <= 1'b0;
    end
  end

  assign enabled_o   = enable_q;
  assign reset_req_o = rst_req_q;
  assign irq_o       = irq_q;
  assign warn_o      = warn_q_f;
  assign wd_flag_o   = wd_flag_q;
  assign count_o     = count;

  AST_RST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> !rst_req_q); // R8
  AST_IRQ_INT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> !$past(rst_mode_q)); // R8
  AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !enable_q); // R3
  AST_EARLY_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    early |=> (irq_q || rst_req_q)); // R5
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q && !fault) |=> enable_q); // R7
endmodule

// File: tb/wdt_window_test.sv
module wdt_window_test;
  localparam int CW = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic enabled_o, reset_req_o, irq_o, warn_o, wd_flag_o;
  logic [CW-1:0] count_o;

  wdt_window uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .enabled_o(enabled_o), .reset_req_o(reset_req_o),
    .irq_o(irq_o), .warn_o(warn_o), .wd_flag_o(wd_flag_o), .count_o(count_o));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0, last_cyc = 0;
  bit mon_on = 0, done = 0;
  int exp_cyc[$];
  int exp_kind[$];
  logic irq_prev = 0, warn_prev = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_ev(int c, int k);
    exp_cyc.push_back(c);
    exp_kind.push_back(k);
  endtask

  task automatic seen(int k);
    checks++;
    if (exp_cyc.size() == 0) begin
      errors++;
      $display("FAIL R3/R5/R6/R8/R9/R11: actual event kind %0d at %0d expected none", k, cyc);
    end else begin
      int c = exp_cyc.pop_front();
      int ek = exp_kind.pop_front();
      if (c != cyc || ek != k) begin
        errors++;
        $display("FAIL R3/R5/R6/R8/R9: actual kind %0d at %0d expected kind %0d at %0d", k, cyc, ek, c);
      end
    end
  endtask

  // kinds: 0 reset pulse, 1 irq rise, 2 warn rise
  always @(negedge clk) begin
    if (mon_on) begin
      if (reset_req_o) seen(0);
      if (irq_o && !irq_prev) seen(1);
      if (warn_o && !warn_prev) seen(2);
    end
    irq_prev  <= irq_o;
    warn_prev <= warn_o;
  end

  task automatic wr(logic [2:0] a, logic [CW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    last_cyc = cyc;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    int c, hold;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 enabled", enabled_o, 0);
    check("R1 outputs", {reset_req_o, irq_o, warn_o, wd_flag_o}, 0);
    check("R1 count", count_o, 24'hFFFFFF);
    mon_on = 1;

    // R2, R3, R9: interrupt mode timeout with warning
    wr(3'd1, 24'd20);
    wr(3'd3, 24'd3);
    wr(3'd0, 24'd1);
    c = last_cyc;
    expect_ev(c + 69, 2);
    expect_ev(c + 84, 1);
    check("R2 load", count_o, 20);
    idle(3);
    check("R2 before tick", count_o, 20);
    idle(1);
    check("R2 first tick", count_o, 19);
    idle(64);
    check("R9 not yet", warn_o, 0);
    idle(1);
    check("R9 warn", warn_o, 1);
    idle(16);
    check("R3 timeout irq", irq_o, 1);
    check("R3 enable cleared", enabled_o, 0);
    check("R8 no reset pulse int mode", wd_flag_o, 0);
    wr(3'd5, 24'd3);
    check("R10 clear irq/warn", {irq_o, warn_o}, 0);

    // R7, R4: sticky enable and valid feed
    wr(3'd3, 24'hFFFF);
    wr(3'd1, 24'd40);
    wr(3'd0, 24'd1);
    wr(3'd0, 24'd0);
    check("R7 sticky enable", enabled_o, 1);
    idle(10);
    wr(3'd4, 24'hAA);
    wr(3'd4, 24'h55);
    check("R4 reload", count_o, 40);
    idle(3);
    check("R4 prescaler restart hold", count_o, 40);
    idle(1);
    check("R4 prescaler restart tick", count_o, 39);

    // R5: window
    wr(3'd2, 24'd20);
    idle(100);
    check("R5 still enabled", enabled_o, 1);
    wr(3'd4, 24'hAA);
    wr(3'd4, 24'h55);
    check("R5 in-window reload", count_o, 40);
    wr(3'd4, 24'hAA);
    wr(3'd4, 24'h55);
    expect_ev(last_cyc, 1);
    check("R5 early no reload", count_o, 40);
    check("R5 early disables", enabled_o, 0);
    wr(3'd5, 24'd1);
    wr(3'd2, 24'hFFFFFF);

    // R6: bad sequences
    wr(3'd0, 24'd1);
    wr(3'd4, 24'hAA);
    wr(3'd3, 24'hFFFF);
    expect_ev(last_cyc, 1);
    check("R6 interleaved write", enabled_o, 0);
    wr(3'd5, 24'd1);
    wr(3'd0, 24'd1);
    idle(2);
    wr(3'd4, 24'h55);
    expect_ev(last_cyc, 1);
    check("R6 lone second key", enabled_o, 0);
    wr(3'd5, 24'd1);

    // R11: feeds ignored while disabled
    hold = count_o;
    wr(3'd4, 24'h12);
    wr(3'd4, 24'hAA);
    wr(3'd4, 24'h55);
    idle(5);
    check("R11 count unchanged", count_o, hold);
    check("R11 no irq", irq_o, 0);

    // R8: reset mode
    wr(3'd1, 24'd2);
    wr(3'd0, 24'd3);
    c = last_cyc;
    expect_ev(c + 12, 0);
    idle(12);
    check("R8 reset pulse", reset_req_o, 1);
    check("R8 flag", wd_flag_o, 1);
    idle(1);
    check("R8 pulse one cycle", reset_req_o, 0);
    check("R8 no irq", irq_o, 0);
    wr(3'd5, 24'd4);
    check("R10 clear flag", wd_flag_o, 0);

    idle(5);
    check("R3/R5/R6/R8/R9 all events seen", exp_cyc.size(), 0);
    finish_run();
  end
endmodule